// File: doc/BRIEF.md
# Timed-Access Write Protection Gate

This block guards a small set of critical control registers (watchdog controls, memory-size setting, wait-state enable, power-fail flag and the like) against stray software writes. It sits beside the register write bus, watches every write, and drives a single permit signal. The protected registers use that signal to qualify their own write enables. The registers themselves and the instruction decoder lie outside the block.

Software unlocks the gate by writing a two-byte key, first 0xAA and then 0x55, to a dedicated unlock address. The 0xAA write starts a budget of a few machine cycles, counted on a machine-cycle strobe input. The 0x55 write and the protected write must both land inside that budget. Any unrelated write to the unlock address, an out-of-order key byte, or the end of the budget returns the gate to idle. A protected write that is granted uses up the unlock, so each protected write needs a fresh key.

Top module: `ta_write_gate`

## Requirements
- R1: While reset is asserted and after reset releases, `wr_permit` is low, and a protected write with no key before it gets no permit.
- R2: A write of 0xAA to the unlock address arms the gate and starts a budget of `WINDOW_MC` strobes, with the strobe in that same cycle not counted. A further 0xAA write restarts the budget.
- R3: A write of 0x55 to the unlock address while the gate is armed and the budget is not spent opens the gate. A protected write while the gate is only armed gets no permit.
- R4: A 0x55 write when the gate is not armed does not open it.
- R5: Any write to the unlock address other than 0xAA, or other than 0x55 while the gate is armed, returns the gate to idle.
- R6: Every `mc_stb` pulse after the 0xAA cycle counts against the budget, including those between the two key bytes. When the `WINDOW_MC`-th pulse arrives, the gate closes, and protected writes after that get no permit. Cycles without a strobe do not count.
- R7: After one protected write has been granted, the gate is idle again.
- R8: `wr_permit` is high only for addresses in `PROT_LIST`. Writes to addresses that are neither protected nor the unlock address get no permit and do not change the gate.
- R9: `wr_permit` is combinational in the same cycle: it equals gate-open AND `wr_en` AND protected-address match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mc_stb | input | 1 | One-cycle pulse marking the end of each machine cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| wr_permit | output | 1 | Qualifies the current write to a protected register |

## Verification
The bench builds the gate with a three-strobe budget and a three-entry protected list, so the generate loop runs with a count other than its default. A budget this short puts both edges of the window within reach in a handful of cycles: the last strobe that still allows a grant, the first strobe that closes the gate, and a strobe that lands on the same cycle as the 0x55 write. Long strobe-free gaps are also driven, to show that only machine cycles count, and a behavioural model is compared with the permit output on every clock.

// File: rtl/ta_gate_pkg.sv
package ta_gate_pkg;
   typedef enum logic [1:0] {
      GATE_IDLE  = 2'd0,
      GATE_ARMED = 2'd1,
      GATE_OPEN  = 2'd2
   } gate_state_t;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/ta_window_timer.sv
module ta_window_timer #(
   parameter int unsigned WINDOW_MC = 3,
   localparam int unsigned CW = ta_gate_pkg::cnt_width(WINDOW_MC)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic clear_i,
   input  logic stb_i,
   output logic live_o,
   output logic last_o
);
   localparam logic [CW-1:0] FULL = CW'(WINDOW_MC);
   localparam logic [CW-1:0] ONE  = CW'(1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        cnt_q <= '0;
      else if (load_i)                   cnt_q <= FULL;
      else if (clear_i)                  cnt_q <= '0;
      else if (stb_i && cnt_q != '0)     cnt_q <= cnt_q - ONE;
   end

   assign live_o = (cnt_q != '0);
   assign last_o = stb_i && (cnt_q == ONE);

   always_comb begin
      assert_budget_bound_R2: assert (!rst_n || cnt_q <= FULL);
   end

   assert_load_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> cnt_q == FULL);

   assert_last_strobe_drains_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_i && cnt_q == ONE && !load_i) |=> cnt_q == '0);
endmodule

// File: rtl/ta_addr_match.sv
module ta_addr_match #(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned NUM_PROT = 4,
   parameter logic [NUM_PROT*ADDR_W-1:0] PROT_LIST = '0,
   parameter logic [ADDR_W-1:0] KEY_ADDR = '0
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              prot_o,
   output logic              key_o
);
   logic [NUM_PROT-1:0] hit;

   for (genvar i = 0; i < NUM_PROT; i++) begin : g_entry
      localparam logic [ADDR_W-1:0] ENTRY = PROT_LIST[i*ADDR_W +: ADDR_W];
      if (ENTRY == KEY_ADDR) begin : g_clash
         $error("protected entry %0d equals the unlock address", i);
      end
      assign hit[i] = (addr_i == ENTRY);
   end

   assign prot_o = |hit;
   assign key_o  = (addr_i == KEY_ADDR);

   always_comb begin
      assert_key_not_protected_R8: assert (!(prot_o && key_o));
   end
endmodule

// File: rtl/ta_key_fsm.sv
module ta_key_fsm
   import ta_gate_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hAA,
   parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_wr_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              grant_i,
   input  logic              expire_i,
   output gate_state_t       state_o,
   output logic              load_o,
   output logic              clear_o
);
   gate_state_t state_q, state_d;

   always_comb begin
      state_d = state_q;
      load_o  = 1'b0;
      clear_o = 1'b0;
      if (key_wr_i) begin
         if (data_i == KEY_FIRST) begin
            state_d = GATE_ARMED;
            load_o  = 1'b1;
         end else if (data_i == KEY_SECOND && state_q == GATE_ARMED && !expire_i) begin
            state_d = GATE_OPEN;
         end else begin
            state_d = GATE_IDLE;
            clear_o = 1'b1;
         end
      end else if (grant_i) begin
         state_d = GATE_IDLE;
         clear_o = 1'b1;
      end else if (expire_i) begin
         state_d = GATE_IDLE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= GATE_IDLE;
      else        state_q <= state_d;
   end

   assign state_o = state_q;

   assert_bad_key_idles_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (key_wr_i && data_i != KEY_FIRST && data_i != KEY_SECOND) |=> state_q == GATE_IDLE);

   assert_open_from_armed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == GATE_OPEN) |-> $past(state_q) != GATE_IDLE);
endmodule

// File: rtl/ta_write_gate.sv
module ta_write_gate
   import ta_gate_pkg::*;
#(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned WINDOW_MC = 3,
   parameter int unsigned NUM_PROT  = 4,
   parameter logic [NUM_PROT*ADDR_W-1:0] PROT_LIST = 32'hC1_8E_F8_D8,
   parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h9F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mc_stb,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_permit
);
   if (WINDOW_MC < 1) begin : g_bad_window
      $error("WINDOW_MC must be at least 1");
   end
   if (NUM_PROT < 1) begin : g_bad_list
      $error("NUM_PROT must be at least 1");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must hold an 8-bit key byte");
   end

   localparam logic [DATA_W-1:0] KEY_A = DATA_W'(8'hAA);
   localparam logic [DATA_W-1:0] KEY_B = DATA_W'(8'h55);

   logic        prot_hit, key_hit, key_wr;
   logic        tmr_load, tmr_clear, tmr_live, tmr_last;
   gate_state_t gate_st;

   ta_addr_match #(
      .ADDR_W(ADDR_W), .NUM_PROT(NUM_PROT), .PROT_LIST(PROT_LIST), .KEY_ADDR(KEY_ADDR)
   ) u_match (
      .addr_i(wr_addr), .prot_o(prot_hit), .key_o(key_hit)
   );

   assign key_wr = wr_en && key_hit;

   ta_key_fsm #(
      .DATA_W(DATA_W), .KEY_FIRST(KEY_A), .KEY_SECOND(KEY_B)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .key_wr_i(key_wr), .data_i(wr_data),
      .grant_i(wr_permit), .expire_i(tmr_last), .state_o(gate_st),
      .load_o(tmr_load), .clear_o(tmr_clear)
   );

   ta_window_timer #(.WINDOW_MC(WINDOW_MC)) u_timer (
      .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .clear_i(tmr_clear),
      .stb_i(mc_stb), .live_o(tmr_live), .last_o(tmr_last)
   );

   assign wr_permit = rst_n && (gate_st == GATE_OPEN) && wr_en && prot_hit;

   always_comb begin
      assert_reset_no_permit_R1: assert (rst_n || !wr_permit);
   end

   assert_open_needs_budget_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_st != GATE_IDLE) |-> tmr_live);

   assert_single_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_permit |=> gate_st == GATE_IDLE);

   assert_other_addr_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !prot_hit && !key_hit && !tmr_last) |=> $stable(gate_st));
endmodule

// File: tb/ta_write_gate_tb.sv
module ta_write_gate_tb_top;
   localparam int W   = 3;
   localparam logic [7:0] KA = 8'h9F;
   localparam logic [7:0] P0 = 8'hD8, P1 = 8'hF8, P2 = 8'h8E, NP = 8'h40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mc_stb = 1'b0, wr_en = 1'b0;
   logic [7:0] wr_addr = '0, wr_data = '0;
   logic       wr_permit;

   int errors = 0, checks = 0;
   int phase = 0, elapsed = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   always #4 clk = ~clk;

   ta_write_gate #(
      .ADDR_W(8), .DATA_W(8), .WINDOW_MC(W), .NUM_PROT(3),
      .PROT_LIST(24'h8E_F8_D8), .KEY_ADDR(KA)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .mc_stb(mc_stb), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .wr_permit(wr_permit)
   );

   function automatic bit is_prot(input logic [7:0] a);
      return (a == P0) || (a == P1) || (a == P2);
   endfunction

   // behavioural reference: key phase and strobes elapsed since 0xAA
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase = 0; elapsed = 0;
      end else if (wr_en && wr_addr == KA) begin
         if (wr_data == 8'hAA) begin
            phase = 1; elapsed = 0;
         end else if (wr_data == 8'h55 && phase == 1 && elapsed + int'(mc_stb) < W) begin
            phase = 2; elapsed += int'(mc_stb);
         end else phase = 0;
      end else if (phase == 2 && wr_en && is_prot(wr_addr)) begin
         phase = 0;
      end else if (phase != 0) begin
         elapsed += int'(mc_stb);
         if (elapsed >= W) phase = 0;
      end
   end

   always @(negedge clk) begin
      automatic bit exp = rst_n && phase == 2 && wr_en && is_prot(wr_addr);
      checks++;
      if (wr_permit !== exp) begin
         errors++;
         $display("FAIL %s model compare: permit=%b expected=%b", cur_req, wr_permit, exp);
      end
   end

   task automatic op(input bit we, input logic [7:0] a, input logic [7:0] d, input bit s);
      @(posedge clk); #1;
      wr_en = we; wr_addr = a; wr_data = d; mc_stb = s;
   endtask

   task automatic prot_chk(input logic [7:0] a, input bit s, input bit exp, input string req);
      cur_req = req;
      op(1'b1, a, 8'h00, s);
      @(negedge clk); #1;
      checks++;
      if (wr_permit !== exp) begin
         errors++;
         $display("FAIL %s protected write: permit=%b expected=%b", req, wr_permit, exp);
      end
   endtask

   task automatic idle(input bit s);
      op(1'b0, NP, 8'h00, s);
   endtask

   initial begin
      // R1: during reset
      wr_en = 1'b1; wr_addr = P0;
      #2; checks++;
      if (wr_permit !== 1'b0) begin
         errors++; $display("FAIL R1 in reset: permit=%b expected=0", wr_permit);
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1; wr_en = 1'b0;
      prot_chk(P0, 1'b0, 1'b0, "R1");

      // R2 R3: valid key, grant
      cur_req = "R3";
      op(1'b1, KA, 8'hAA, 1'b1); op(1'b1, KA, 8'h55, 1'b1);
      prot_chk(P1, 1'b0, 1'b1, "R3");
      // R7: one-shot
      prot_chk(P1, 1'b0, 1'b0, "R7");

      // R6: extra machine cycle between keys spends the budget
      cur_req = "R6";
      op(1'b1, KA, 8'hAA, 1'b0); idle(1'b1); op(1'b1, KA, 8'h55, 1'b1); idle(1'b1);
      prot_chk(P2, 1'b0, 1'b0, "R6");
      // R6: last strobe that still leaves the window open
      op(1'b1, KA, 8'hAA, 1'b1); op(1'b1, KA, 8'h55, 1'b1); idle(1'b1);
      prot_chk(P2, 1'b0, 1'b1, "R6");
      // R6: strobe-free cycles do not count
      op(1'b1, KA, 8'hAA, 1'b0);
      for (int i = 0; i < 6; i++) idle(1'b0);
      op(1'b1, KA, 8'h55, 1'b1);
      for (int i = 0; i < 5; i++) idle(1'b0);
      prot_chk(P0, 1'b1, 1'b1, "R6");
      // R6: strobe with 0x55 exhausts the budget
      op(1'b1, KA, 8'hAA, 1'b0); idle(1'b1); idle(1'b1); op(1'b1, KA, 8'h55, 1'b1);
      prot_chk(P0, 1'b0, 1'b0, "R6");

      // R4: 0x55 alone
      cur_req = "R4";
      op(1'b1, KA, 8'h55, 1'b0);
      prot_chk(P0, 1'b0, 1'b0, "R4");

      // R5: wrong byte after arm; repeated 0x55 after open
      cur_req = "R5";
      op(1'b1, KA, 8'hAA, 1'b0); op(1'b1, KA, 8'h12, 1'b0); op(1'b1, KA, 8'h55, 1'b0);
      prot_chk(P0, 1'b0, 1'b0, "R5");
      op(1'b1, KA, 8'hAA, 1'b0); op(1'b1, KA, 8'h55, 1'b0); op(1'b1, KA, 8'h55, 1'b0);
      prot_chk(P0, 1'b0, 1'b0, "R5");

      // R2: re-arm restarts the budget
      cur_req = "R2";
      op(1'b1, KA, 8'hAA, 1'b0); idle(1'b1); idle(1'b1);
      op(1'b1, KA, 8'hAA, 1'b1); idle(1'b1); op(1'b1, KA, 8'h55, 1'b1);
      prot_chk(P1, 1'b0, 1'b1, "R2");

      // R3: armed only, no grant
      cur_req = "R3";
      op(1'b1, KA, 8'hAA, 1'b0);
      prot_chk(P1, 1'b0, 1'b0, "R3");

      // R8: unprotected address gets nothing and leaves the gate open
      cur_req = "R8";
      op(1'b1, KA, 8'hAA, 1'b0); op(1'b1, KA, 8'h55, 1'b0);
      prot_chk(NP, 1'b0, 1'b0, "R8");
      prot_chk(P2, 1'b0, 1'b1, "R8");

      // R9: no write enable, no permit
      cur_req = "R9";
      op(1'b1, KA, 8'hAA, 1'b0); op(1'b1, KA, 8'h55, 1'b0);
      op(1'b0, P0, 8'h00, 1'b0);
      @(negedge clk); #1; checks++;
      if (wr_permit !== 1'b0) begin
         errors++; $display("FAIL R9 idle bus: permit=%b expected=0", wr_permit);
      end
      prot_chk(P0, 1'b0, 1'b1, "R9");

      idle(1'b0); idle(1'b0);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule